// File: doc/BRIEF.md
# Configuration Request Router

This block decides where a single host configuration request goes. A request carries bus, device, function and register numbers, a read/write flag, byte enables and write data. Bus 0 is checked first against a small set of internal devices. A device claims the request when its index is inside the local range, its enable bit is set, and its function 0 is marked present. Any other bus-0 request goes out on the forwarding link as a Type 0 request. A non-zero bus number is compared with the local bridge's secondary-to-subordinate window. A hit goes to the bridge port, and any other bus goes to the forwarding link as a Type 1 request.

The block handles one request at a time. After it accepts a request it asserts one issue pulse toward the chosen target. It then waits for that target's response, which says whether anything claimed the access. Finally it returns a completion to the host. A completion that nothing claimed is a master abort: a read returns all ones, and a write is dropped with zero data. The enable mask, the function-0-present mask and the bus window are live inputs. They are captured at the moment a request is accepted.

Top module: `cfg_route_decoder`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `loc_valid`, `dn_valid` and `cpl_valid` are 0.
- R2: On bus 0, a device number below NDEV whose bits are set in both `dev_enable` and `fn0_present` is claimed locally, whatever the function number. `loc_valid` pulses with `loc_dev` equal to the device number, and `dn_valid` stays 0.
- R3: A bus-0 request that is not claimed locally is forwarded with `dn_valid`=1, `dn_bridge`=0 (forwarding link) and `dn_type`=0 (Type 0). This covers a device number at or above NDEV, a disabled device, and a device whose function 0 is absent.
- R4: A non-zero bus with `sec_bus` <= bus <= `sub_bus` goes to the bridge port with `dn_bridge`=1. `dn_type` is 0 when the bus equals `sec_bus` and 1 otherwise.
- R5: A non-zero bus outside that window is forwarded with `dn_bridge`=0 and `dn_type`=1 (Type 1). An empty window (`sub_bus` < `sec_bus`) claims no bus.
- R6: Exactly one issue pulse (`loc_valid` or `dn_valid`) appears in the cycle after acceptance. The `out_*` payload copies the accepted request and holds until the completion.
- R7: The masks and bus window are used only as they stand in the accepting cycle. Changing them afterwards does not alter the route.
- R8: `req_ready` drops in the cycle after acceptance and returns only after the completion cycle. A `req_valid` raised while busy is ignored and does not disturb the payload.
- R9: `cpl_valid` pulses for one cycle, in the cycle after `tgt_rsp_valid` is seen while waiting. With `tgt_rsp_hit`=1, `cpl_abort`=0 and `cpl_rdata` is `tgt_rsp_rdata` for a read and 0 for a write.
- R10: With `tgt_rsp_hit`=0, `cpl_abort`=1. `cpl_rdata` is all ones for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_reg | input | REG_W | Register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| dev_enable | input | NDEV | Per-device enable mask |
| fn0_present | input | NDEV | Per-device function-0-present mask |
| sec_bus | input | 8 | Bridge secondary bus number |
| sub_bus | input | 8 | Bridge subordinate bus number |
| loc_valid | output | 1 | Issue pulse to an internal device |
| loc_dev | output | 5 | Claiming internal device index |
| dn_valid | output | 1 | Issue pulse downstream |
| dn_bridge | output | 1 | 1 = bridge port, 0 = forwarding link |
| dn_type | output | 1 | 0 = Type 0, 1 = Type 1 |
| out_bus | output | 8 | Accepted bus number |
| out_dev | output | 5 | Accepted device number |
| out_fn | output | 3 | Accepted function number |
| out_reg | output | REG_W | Accepted register number |
| out_write | output | 1 | Accepted write flag |
| out_be | output | DATA_W/8 | Accepted byte enables |
| out_wdata | output | DATA_W | Accepted write data |
| tgt_rsp_valid | input | 1 | Target response present |
| tgt_rsp_hit | input | 1 | 1 = claimed, 0 = unclaimed |
| tgt_rsp_rdata | input | DATA_W | Target read data |
| cpl_valid | output | 1 | Completion to host |
| cpl_abort | output | 1 | Completion is a master abort |
| cpl_rdata | output | DATA_W | Completion read data |

## Verification
The assertions assume that a target raises `tgt_rsp_valid` only after it has seen an issue pulse. They also assume that reset is held from time zero until the first clock edge. The stimulus satisfies both. Each request is presented only while `req_ready` is high. The response is driven exactly once, in the waiting cycle that follows the issue pulse. The masks, the bus window and a stray `req_valid` are disturbed only after the accepting edge, which exercises R7 and R8 without breaking the handshake order the checks rely on.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;

    typedef enum logic [1:0] {
        ROUTE_LOCAL  = 2'd0,
        ROUTE_LINK   = 2'd1,
        ROUTE_BRIDGE = 2'd2
    } route_e;

    typedef enum logic {
        CFG_TYPE0 = 1'b0,
        CFG_TYPE1 = 1'b1
    } cfg_type_e;

    typedef struct packed {
        route_e    route;
        cfg_type_e ctype;
    } route_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CPL   = 2'd3
    } ctrl_state_e;

    // Non-zero bus inside the inclusive bridge window
    function automatic logic bus_in_window(input logic [BUS_W-1:0] bus,
                                           input logic [BUS_W-1:0] lo,
                                           input logic [BUS_W-1:0] hi);
        return (bus != '0) && (bus >= lo) && (bus <= hi);
    endfunction

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_route_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [NDEV-1:0]  dev_enable,
    input  logic [NDEV-1:0]  fn0_present,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_dec_t       dec
);

    logic [NDEV-1:0] claim_vec;
    logic            local_claim;
    logic            in_window;

    // One claim term per internal device
    for (genvar g = 0; g < NDEV; g++) begin : g_claim
        assign claim_vec[g] = (dev == DEV_W'(g)) && dev_enable[g] && fn0_present[g];
    end

    assign local_claim = (bus == '0) && (|claim_vec);
    assign in_window   = bus_in_window(bus, sec_bus, sub_bus);

    always_comb begin
        if (bus == '0) begin
            dec.route = local_claim ? ROUTE_LOCAL : ROUTE_LINK;
            dec.ctype = CFG_TYPE0;
        end else if (in_window) begin
            dec.route = ROUTE_BRIDGE;
            dec.ctype = (bus == sec_bus) ? CFG_TYPE0 : CFG_TYPE1;
        end else begin
            dec.route = ROUTE_LINK;
            dec.ctype = CFG_TYPE1;
        end
    end

endmodule

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
    import cfg_route_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  route_dec_t        dec_in,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              loc_valid,
    output logic              dn_valid,
    output logic              dn_bridge,
    output logic              dn_type,
    output logic [BUS_W-1:0]  out_bus,
    output logic [DEV_W-1:0]  out_dev,
    output logic [FN_W-1:0]   out_fn,
    output logic [REG_W-1:0]  out_reg,
    output logic              out_write,
    output logic [BE_W-1:0]   out_be,
    output logic [DATA_W-1:0] out_wdata,
    input  logic              tgt_rsp_valid,
    input  logic              tgt_rsp_hit,
    input  logic [DATA_W-1:0] tgt_rsp_rdata,
    output logic              cpl_valid,
    output logic              cpl_abort,
    output logic [DATA_W-1:0] cpl_rdata
);

    ctrl_state_e       state;
    route_dec_t        dec_q;
    logic [BUS_W-1:0]  sec_q, sub_q;
    logic              hit_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dec_q     <= '{route: ROUTE_LINK, ctype: CFG_TYPE0};
            sec_q     <= '0;
            sub_q     <= '0;
            hit_q     <= 1'b0;
            rdata_q   <= '0;
            out_bus   <= '0;
            out_dev   <= '0;
            out_fn    <= '0;
            out_reg   <= '0;
            out_write <= 1'b0;
            out_be    <= '0;
            out_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    dec_q     <= dec_in;
                    sec_q     <= sec_bus;
                    sub_q     <= sub_bus;
                    out_bus   <= req_bus;
                    out_dev   <= req_dev;
                    out_fn    <= req_fn;
                    out_reg   <= req_reg;
                    out_write <= req_write;
                    out_be    <= req_be;
                    out_wdata <= req_wdata;
                    state     <= ST_ISSUE;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (tgt_rsp_valid) begin
                    hit_q   <= tgt_rsp_hit;
                    rdata_q <= tgt_rsp_rdata;
                    state   <= ST_CPL;
                end
                ST_CPL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign loc_valid = (state == ST_ISSUE) && (dec_q.route == ROUTE_LOCAL);
    assign dn_valid  = (state == ST_ISSUE) && (dec_q.route != ROUTE_LOCAL);
    assign dn_bridge = (dec_q.route == ROUTE_BRIDGE);
    assign dn_type   = dec_q.ctype;
    assign cpl_valid = (state == ST_CPL);
    assign cpl_abort = !hit_q;

    always_comb begin
        if (out_write)  cpl_rdata = '0;
        else if (hit_q) cpl_rdata = rdata_q;
        else            cpl_rdata = '1;
    end

    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r6_issue_after_accept: assert property (@(posedge clk) disable iff (rst)
        (loc_valid || dn_valid) |-> $past(req_valid && req_ready));

    a_r6_payload_held: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(out_bus) && $stable(out_dev) && $stable(out_wdata)));

    a_r9_cpl_follows_rsp: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> $past(tgt_rsp_valid));

    a_r4_bridge_in_window: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_bridge) |-> bus_in_window(out_bus, sec_q, sub_q));

endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder
    import cfg_route_pkg::*;
#(
    parameter int NDEV   = 4,
    parameter int REG_W  = 8,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NDEV-1:0]   dev_enable,
    input  logic [NDEV-1:0]   fn0_present,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              loc_valid,
    output logic [DEV_W-1:0]  loc_dev,
    output logic              dn_valid,
    output logic              dn_bridge,
    output logic              dn_type,
    output logic [BUS_W-1:0]  out_bus,
    output logic [DEV_W-1:0]  out_dev,
    output logic [FN_W-1:0]   out_fn,
    output logic [REG_W-1:0]  out_reg,
    output logic              out_write,
    output logic [BE_W-1:0]   out_be,
    output logic [DATA_W-1:0] out_wdata,
    input  logic              tgt_rsp_valid,
    input  logic              tgt_rsp_hit,
    input  logic [DATA_W-1:0] tgt_rsp_rdata,
    output logic              cpl_valid,
    output logic              cpl_abort,
    output logic [DATA_W-1:0] cpl_rdata
);

    route_dec_t dec;

    cfg_route_decode #(.NDEV(NDEV)) u_decode (
        .bus         (req_bus),
        .dev         (req_dev),
        .dev_enable  (dev_enable),
        .fn0_present (fn0_present),
        .sec_bus     (sec_bus),
        .sub_bus     (sub_bus),
        .dec         (dec)
    );

    cfg_route_ctrl #(.REG_W(REG_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_bus       (req_bus),
        .req_dev       (req_dev),
        .req_fn        (req_fn),
        .req_reg       (req_reg),
        .req_write     (req_write),
        .req_be        (req_be),
        .req_wdata     (req_wdata),
        .dec_in        (dec),
        .sec_bus       (sec_bus),
        .sub_bus       (sub_bus),
        .loc_valid     (loc_valid),
        .dn_valid      (dn_valid),
        .dn_bridge     (dn_bridge),
        .dn_type       (dn_type),
        .out_bus       (out_bus),
        .out_dev       (out_dev),
        .out_fn        (out_fn),
        .out_reg       (out_reg),
        .out_write     (out_write),
        .out_be        (out_be),
        .out_wdata     (out_wdata),
        .tgt_rsp_valid (tgt_rsp_valid),
        .tgt_rsp_hit   (tgt_rsp_hit),
        .tgt_rsp_rdata (tgt_rsp_rdata),
        .cpl_valid     (cpl_valid),
        .cpl_abort     (cpl_abort),
        .cpl_rdata     (cpl_rdata)
    );

    assign loc_dev = out_dev;

    a_r2_local_bus_zero: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> ((out_bus == '0) && (int'(loc_dev) < NDEV)));

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !loc_valid && !dn_valid && !cpl_valid));

endmodule

// File: tb/cfg_route_decoder_tb.sv
module cfg_route_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV   = 4;
    localparam int REG_W  = 8;
    localparam int DATA_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [7:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  dev_enable = '0;
    logic [3:0]  fn0_present = '0;
    logic [7:0]  sec_bus = '0;
    logic [7:0]  sub_bus = '0;
    logic        loc_valid;
    logic [4:0]  loc_dev;
    logic        dn_valid, dn_bridge, dn_type;
    logic [7:0]  out_bus;
    logic [4:0]  out_dev;
    logic [2:0]  out_fn;
    logic [7:0]  out_reg;
    logic        out_write;
    logic [3:0]  out_be;
    logic [31:0] out_wdata;
    logic        tgt_rsp_valid = 1'b0;
    logic        tgt_rsp_hit = 1'b0;
    logic [31:0] tgt_rsp_rdata = '0;
    logic        cpl_valid, cpl_abort;
    logic [31:0] cpl_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_route_decoder #(.NDEV(NDEV), .REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .dev_enable(dev_enable), .fn0_present(fn0_present),
        .sec_bus(sec_bus), .sub_bus(sub_bus),
        .loc_valid(loc_valid), .loc_dev(loc_dev),
        .dn_valid(dn_valid), .dn_bridge(dn_bridge), .dn_type(dn_type),
        .out_bus(out_bus), .out_dev(out_dev), .out_fn(out_fn), .out_reg(out_reg),
        .out_write(out_write), .out_be(out_be), .out_wdata(out_wdata),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_hit(tgt_rsp_hit),
        .tgt_rsp_rdata(tgt_rsp_rdata),
        .cpl_valid(cpl_valid), .cpl_abort(cpl_abort), .cpl_rdata(cpl_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // One full request: accept, issue, respond, complete
    task automatic run_txn(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                           input logic [7:0] rg, input logic we, input logic [3:0] be,
                           input logic [31:0] wd, input logic [3:0] en, input logic [3:0] f0,
                           input logic [7:0] sec, input logic [7:0] sub,
                           input logic hit, input logic [31:0] rd);
        logic exp_loc, exp_bridge, exp_type;
        logic [31:0] exp_data;
        string tag;
        exp_loc = 1'b0; exp_bridge = 1'b0; exp_type = 1'b0;
        if (bus == 0) begin
            if (dev < NDEV && en[dev[1:0]] && f0[dev[1:0]]) begin
                exp_loc = 1'b1; tag = "R2";
            end else begin
                tag = "R3";
            end
        end else if (bus >= sec && bus <= sub) begin
            exp_bridge = 1'b1; exp_type = (bus != sec); tag = "R4";
        end else begin
            exp_type = 1'b1; tag = "R5";
        end
        exp_data = we ? 32'h0 : (hit ? rd : 32'hFFFF_FFFF);

        check(req_ready == 1'b1, "R8 ready before request", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_bus = bus; req_dev = dev; req_fn = fn; req_reg = rg;
        req_write = we; req_be = be; req_wdata = wd;
        dev_enable = en; fn0_present = f0; sec_bus = sec; sub_bus = sub;
        @(posedge clk);
        #1;
        // R7: disturb config after acceptance; R8: stray request while busy
        dev_enable = ~en; fn0_present = ~f0; sec_bus = ~sec; sub_bus = ~sub;
        req_bus = bus ^ 8'h55; req_dev = dev ^ 5'h0A; req_wdata = ~wd;
        @(negedge clk);
        check({loc_valid, dn_valid, dn_valid & dn_bridge, dn_valid & dn_type}
                  == {exp_loc, ~exp_loc, exp_bridge, exp_type},
              {tag, " R7 route"},
              64'({loc_valid, dn_valid, dn_bridge, dn_type}),
              64'({exp_loc, ~exp_loc, exp_bridge, exp_type}));
        if (exp_loc)
            check(loc_dev == dev, "R2 loc_dev", 64'(loc_dev), 64'(dev));
        check({out_bus, out_dev, out_fn, out_reg, out_write, out_be} ==
                  {bus, dev, fn, rg, we, be} && out_wdata == wd,
              "R6 payload", 64'({out_bus, out_dev, out_wdata}), 64'({bus, dev, wd}));
        @(negedge clk);
        check({req_ready, loc_valid, dn_valid, cpl_valid} == 4'b0000,
              "R8 busy no pulse", 64'({req_ready, loc_valid, dn_valid, cpl_valid}), 64'h0);
        check(out_bus == bus && out_wdata == wd, "R8 payload held while busy",
              64'({out_bus, out_wdata}), 64'({bus, wd}));
        tgt_rsp_valid = 1'b1; tgt_rsp_hit = hit; tgt_rsp_rdata = rd;
        @(negedge clk);
        tgt_rsp_valid = 1'b0; req_valid = 1'b0;
        check({cpl_valid, cpl_abort} == {1'b1, ~hit},
              hit ? "R9 completion" : "R10 master abort",
              64'({cpl_valid, cpl_abort}), 64'({1'b1, ~hit}));
        check(cpl_rdata == exp_data, hit ? "R9 data" : "R10 abort data",
              64'(cpl_rdata), 64'(exp_data));
        check(req_ready == 1'b0, "R8 ready low in completion", 64'(req_ready), 64'h0);
        @(negedge clk);
        check({req_ready, cpl_valid, loc_valid, dn_valid} == 4'b1000,
              "R9 single completion pulse",
              64'({req_ready, cpl_valid, loc_valid, dn_valid}), 64'h8);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req_ready, loc_valid, dn_valid, cpl_valid} == 4'b1000, "R1 in reset",
              64'({req_ready, loc_valid, dn_valid, cpl_valid}), 64'h8);
        rst = 1'b0;
        @(negedge clk);
        check({req_ready, loc_valid, dn_valid, cpl_valid} == 4'b1000, "R1 after reset",
              64'({req_ready, loc_valid, dn_valid, cpl_valid}), 64'h8);

        // Bus 0: every mask pair against devices inside and beyond the local range
        for (int e = 0; e < 16; e++)
            for (int p = 0; p < 16; p++)
                for (int d = 0; d < 8; d++)
                    run_txn(8'h00, 5'(d + (d >= 6 ? 20 : 0)), 3'(e + d), 8'(p * 4),
                            d[0], 4'(e ^ p), {8'(e), 8'(p), 8'(d), 8'hA5},
                            4'(e), 4'(p), 8'h05, 8'h09,
                            ((e + p + d) % 3) != 0, {8'(d), 8'(p), 8'(e), 8'h3C});

        // Non-zero buses against normal, single-bus, empty and full windows
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 256; b++) begin
                logic [7:0] s, u;
                case (w)
                    0: begin s = 8'h05; u = 8'h09; end
                    1: begin s = 8'h20; u = 8'h20; end
                    2: begin s = 8'h09; u = 8'h05; end
                    default: begin s = 8'h01; u = 8'hFF; end
                endcase
                run_txn(8'(b), 5'(b), 3'(b >> 5), 8'(b), b[1], 4'(b), {24'(b), 8'(w)},
                        4'hF, 4'hF, s, u, b[2] ^ b[0], {8'(w), 24'(b * 7)});
            end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule